// File: doc/BRIEF.md
# Handshake Pipeline Functional Test Sequencer

This block is a synchronous controller that tests a linear pipeline built from request/acknowledge handshakes. It adds nothing inside the pipeline. It sits at the two ends of the pipeline. On the input side it acts as a valid/ready source that offers words to the first stage. On the output side it acts as a valid/ready sink whose ready line is the acknowledge returned to the last stage. It runs two sweeps and reports whether the pipeline carried every word intact.

Both sweeps start from an empty pipeline, so the sequencer first drains the pipeline by holding the sink ready high.

The forward sweep sends one lone word through the empty pipeline. Every stage then receives a word while it is empty, which is the condition under which a setup-type fault corrupts data. The returned word must equal the one sent.

The reverse sweep fills every stage while the sink ready is held low. It then accepts exactly one word, which leaves one empty slot. It waits for that slot to travel back to the input, and only then drains the rest. Each stage boundary therefore sees a word arrive while the word behind it is already waiting, which is where hold-type faults overwrite data.

All words come from a run counter k, encoded as k XOR a mask with every odd bit set. Every word differs from the others, so a full or partial overwrite always changes a drained value.

The source follows the usual valid/ready rule. Once `src_valid` is raised, `src_data` stays constant until `src_ready` accepts it. The sequencer leaves this rule only when a stall timeout ends the run. The sink ready is driven by the sweep itself and never depends on `snk_valid` in the same cycle. The pipeline therefore sees back-pressure exactly where the test intends it. `done`, `pass`, `fault_kind` and `fault_index` are plain status pins that hold their values until the next `start`.

Top module: `hs_pipe_test_seq`

## Requirements
- R1: After reset, `done`, `pass`, `src_valid` and `snk_ready` are 0 and `fault_kind` is 0. While `done` is 1, `src_valid` and `snk_ready` stay 0.
- R2: After `start`, `snk_ready` stays 1 until `snk_valid` has been 0 for QUIET consecutive cycles. No word is offered before then, so the pipeline is empty when the first word enters.
- R3: The forward sweep offers exactly one word, equal to word(1), where word(k) = k XOR a mask with every odd bit position set. It offers no further word until that word has been taken back at the sink with `snk_ready` high.
- R4: If the returned forward word differs from word(1), the run ends with `done`=1, `pass`=0, `fault_kind`=1 and `fault_index`=0. No fill word is offered in that case.
- R5: The reverse sweep offers DEPTH words, word(2) through word(DEPTH+1), in order. `snk_ready` stays 0 while they are offered and until all of them have been accepted.
- R6: With the pipeline full, exactly one word is accepted at the sink. `snk_ready` then stays 0 for at least DEPTH cycles before draining resumes.
- R7: The remaining words are drained with `snk_ready` held high, and the words are compared in order: the i-th drained word (0-based, the single-release word being number 0) must equal word(2+i). The first mismatch ends the run with `fault_kind`=2, `pass`=0 and `fault_index` set to i, which is less than DEPTH.
- R8: If all DEPTH+1 returned words match, the run ends with `done`=1, `pass`=1, `fault_kind`=0.
- R9: A wait state that makes no progress for TIMEOUT cycles ends the run with `fault_kind`=3. The drain phase counts the whole phase. In the forward sweep `fault_index` is 0.
- R10: `start` is ignored while a run is in progress. The results hold while `done` is 1 until the next `start`, which clears them and begins a new run.
- R11: While `src_valid` is 1 and `src_ready` is 0, `src_valid` and `src_data` stay unchanged on the next cycle unless the run ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (honoured when idle or done) |
| src_valid | output | 1 | Word offered to pipeline input |
| src_ready | input | 1 | Pipeline input accepts the offered word |
| src_data | output | WIDTH | Word offered to pipeline input |
| snk_valid | input | 1 | Pipeline output holds a word |
| snk_ready | output | 1 | Acknowledge to the pipeline output |
| snk_data | input | WIDTH | Word presented at pipeline output |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every word correct |
| fault_kind | output | 2 | 0 none, 1 forward corruption, 2 reverse overwrite, 3 stall timeout |
| fault_index | output | $clog2(DEPTH) | Index of the first bad word within its sweep |

## Verification
The bench goes after four things.

It preloads stale words before a run. A sequencer that skipped the drain or ended it early would inject its first word into an occupied pipeline.

It injects a zeroing fault on an empty receiver at random stage boundaries. A design that let the fill begin before the lone word returned, or that compared against the wrong value, would report a pass or the wrong fault kind.

It injects a fault that copies the word two stages back whenever two adjacent stages move together. A design that acknowledged during the fill, released more than one word at once, or compared the drained words out of order would miss the resulting duplicate.

Random pipeline freezes stress the back-pressure rules. A dead output stage must produce a timeout rather than a hang.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DRAIN,
    S_FWD_INJECT,
    S_FWD_WAIT,
    S_FWD_CHECK,
    S_FILL,
    S_BUBBLE,
    S_DRAIN_CHECK,
    S_DONE
  } pts_state_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_FWD   = 2'd1,
    FK_REV   = 2'd2,
    FK_STALL = 2'd3
  } pts_fault_e;

endpackage

// File: rtl/pts_word_gen.sv
// Maps a run counter value to a test word: counter bits XOR a mask that is 1
// on every odd bit position; bits above the counter width carry the mask only.
module pts_word_gen #(
  parameter int WIDTH = 16,
  parameter int SEQW  = 5
) (
  input  logic [SEQW-1:0]  seq,
  output logic [WIDTH-1:0] word
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b < SEQW) begin : g_cnt
      assign word[b] = seq[b] ^ 1'(b % 2);
    end else begin : g_pad
      assign word[b] = 1'(b % 2);
    end
  end

endmodule

// File: rtl/pts_stall_timer.sv
// Counts cycles without progress; expired is raised once LIMIT cycles pass.
module pts_stall_timer #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != TW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == TW'(LIMIT));

endmodule

// File: rtl/pts_quiet_detect.sv
// Raises quiet after QUIET consecutive cycles with busy low.
module pts_quiet_detect #(
  parameter int QUIET = 4,
  localparam int QW = $clog2(QUIET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy,
  output logic quiet
);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || busy) begin
      cnt_q <= '0;
    end else if (cnt_q != QW'(QUIET)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quiet = (cnt_q == QW'(QUIET));

endmodule

// File: rtl/hs_pipe_test_seq.sv
module hs_pipe_test_seq
  import pts_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 16,
  parameter int QUIET   = 4,
  parameter int TIMEOUT = 64,
  localparam int IW = (DEPTH < 3) ? 1 : $clog2(DEPTH),
  localparam int SW = $clog2(DEPTH + 2) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             src_valid,
  input  logic             src_ready,
  output logic [WIDTH-1:0] src_data,
  input  logic             snk_valid,
  output logic             snk_ready,
  input  logic [WIDTH-1:0] snk_data,
  output logic             done,
  output logic             pass,
  output logic [1:0]       fault_kind,
  output logic [IW-1:0]    fault_index
);

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  pts_state_e         st_q, st_d;
  pts_fault_e         fk_d;
  logic [SW-1:0]      seq_q, chk_q;
  logic [IW-1:0]      idx_q, settle_q;
  logic               popped_q, fwd_bad_q;
  logic [WIDTH-1:0]   exp_word;
  logic               push, pop, miss;
  logic               expired, quiet, tmr_run, tmr_clr;
  logic               go;

  // word generators: one for the source side, one for the expected value
  pts_word_gen #(.WIDTH(WIDTH), .SEQW(SW)) u_src_word (
    .seq (seq_q),
    .word(src_data)
  );

  pts_word_gen #(.WIDTH(WIDTH), .SEQW(SW)) u_exp_word (
    .seq (chk_q),
    .word(exp_word)
  );

  assign src_valid = (st_q == S_FWD_INJECT) || (st_q == S_FILL);
  assign snk_ready = (st_q == S_DRAIN) || (st_q == S_FWD_WAIT) ||
                     (st_q == S_DRAIN_CHECK) || ((st_q == S_BUBBLE) && !popped_q);

  assign push = src_valid && src_ready;
  assign pop  = snk_ready && snk_valid;
  assign miss = pop && (snk_data != exp_word);
  assign go   = start && ((st_q == S_IDLE) || (st_q == S_DONE));

  assign tmr_run = (st_q == S_DRAIN) || (st_q == S_FWD_INJECT) || (st_q == S_FWD_WAIT) ||
                   (st_q == S_FILL) || (st_q == S_DRAIN_CHECK) ||
                   ((st_q == S_BUBBLE) && !popped_q);
  assign tmr_clr = (st_d != st_q) || ((push || pop) && (st_q != S_DRAIN));

  pts_stall_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clr),
    .run    (tmr_run),
    .expired(expired)
  );

  pts_quiet_detect #(.QUIET(QUIET)) u_quiet (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(st_q != S_DRAIN),
    .busy (snk_valid),
    .quiet(quiet)
  );

  // next state and the fault class recorded on entry to DONE
  always_comb begin
    st_d = st_q;
    fk_d = FK_NONE;
    unique case (st_q)
      S_IDLE, S_DONE: begin
        if (start) st_d = S_DRAIN;
      end
      S_DRAIN: begin
        if (expired) begin
          st_d = S_DONE;
          fk_d = FK_STALL;
        end else if (quiet && !snk_valid) begin
          st_d = S_FWD_INJECT;
        end
      end
      S_FWD_INJECT: begin
        if (expired) begin
          st_d = S_DONE;
          fk_d = FK_STALL;
        end else if (push) begin
          st_d = S_FWD_WAIT;
        end
      end
      S_FWD_WAIT: begin
        if (expired) begin
          st_d = S_DONE;
          fk_d = FK_STALL;
        end else if (pop) begin
          st_d = S_FWD_CHECK;
        end
      end
      S_FWD_CHECK: begin
        if (fwd_bad_q) begin
          st_d = S_DONE;
          fk_d = FK_FWD;
        end else begin
          st_d = S_FILL;
        end
      end
      S_FILL: begin
        if (expired) begin
          st_d = S_DONE;
          fk_d = FK_STALL;
        end else if (push && (idx_q == LAST)) begin
          st_d = S_BUBBLE;
        end
      end
      S_BUBBLE: begin
        if (!popped_q) begin
          if (expired) begin
            st_d = S_DONE;
            fk_d = FK_STALL;
          end else if (miss) begin
            st_d = S_DONE;
            fk_d = FK_REV;
          end
        end else if (settle_q == LAST) begin
          st_d = S_DRAIN_CHECK;
        end
      end
      S_DRAIN_CHECK: begin
        if (expired) begin
          st_d = S_DONE;
          fk_d = FK_STALL;
        end else if (miss) begin
          st_d = S_DONE;
          fk_d = FK_REV;
        end else if (pop && (idx_q == LAST)) begin
          st_d = S_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      seq_q       <= '0;
      chk_q       <= '0;
      idx_q       <= '0;
      settle_q    <= '0;
      popped_q    <= 1'b0;
      fwd_bad_q   <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fault_kind  <= FK_NONE;
      fault_index <= '0;
    end else begin
      st_q <= st_d;

      if (go) begin
        seq_q       <= SW'(1);
        chk_q       <= SW'(1);
        idx_q       <= '0;
        fwd_bad_q   <= 1'b0;
        done        <= 1'b0;
        pass        <= 1'b0;
        fault_kind  <= FK_NONE;
        fault_index <= '0;
      end

      if (push) seq_q <= seq_q + 1'b1;

      unique case (st_q)
        S_FWD_WAIT: begin
          if (pop) begin
            fwd_bad_q <= miss;
            chk_q     <= chk_q + 1'b1;
          end
        end
        S_FILL: begin
          if (push) begin
            idx_q    <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            settle_q <= '0;
            popped_q <= 1'b0;
          end
        end
        S_BUBBLE: begin
          if (!popped_q) begin
            if (pop) begin
              popped_q <= 1'b1;
              chk_q    <= chk_q + 1'b1;
            end
          end else begin
            settle_q <= settle_q + 1'b1;
            if (settle_q == LAST) idx_q <= IW'(1);
          end
        end
        S_DRAIN_CHECK: begin
          if (pop && !miss) begin
            chk_q <= chk_q + 1'b1;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase

      if ((st_d == S_DONE) && (st_q != S_DONE)) begin
        done        <= 1'b1;
        pass        <= (fk_d == FK_NONE);
        fault_kind  <= fk_d;
        fault_index <= idx_q;
      end
    end
  end

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
  parameter int WIDTH = 16,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             src_valid,
  input logic             src_ready,
  input logic [WIDTH-1:0] src_data,
  input logic             snk_ready,
  input logic             done,
  input logic             pass,
  input logic [1:0]       fault_kind,
  input logic [IW-1:0]    fault_index
);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!src_valid && !snk_ready));

  assert_fwd_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 2'd1) |-> (fault_index == '0));

  assert_no_ack_while_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> !snk_ready);

  assert_fail_no_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind != 2'd0) |-> !pass);

  assert_pass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && fault_kind == 2'd0));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fault_kind) && $stable(fault_index)));

  assert_offer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> ((src_valid && $stable(src_data)) || done));

endmodule

bind hs_pipe_test_seq pts_checker #(.WIDTH(WIDTH), .IW(IW)) u_pts_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .src_data   (src_data),
  .snk_ready  (snk_ready),
  .done       (done),
  .pass       (pass),
  .fault_kind (fault_kind),
  .fault_index(fault_index)
);

// File: tb/sim_hs_pipe_test_seq.sv
module sim_hs_pipe_test_seq;

  localparam int D  = 8;
  localparam int W  = 16;
  localparam int Q  = 4;
  localparam int TO = 64;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic          src_valid, src_ready, snk_valid, snk_ready;
  logic [W-1:0]  src_data, snk_data;
  logic          done, pass;
  logic [1:0]    fault_kind;
  logic [IW-1:0] fault_index;

  hs_pipe_test_seq #(.DEPTH(D), .WIDTH(W), .QUIET(Q), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .done(done), .pass(pass), .fault_kind(fault_kind), .fault_index(fault_index)
  );

  // ---------------- pipeline model with optional faults ----------------
  int            fwd_at = 0;    // stage that zeroes a word entering it while empty
  int            hold_at = 0;   // stage that copies from two back when both neighbours move
  logic          stall = 1'b0;  // output stage never presents data
  int            frz_pct = 0;
  logic          frz = 1'b0;
  logic          pre = 1'b0;
  logic [W-1:0]  pre_base = '0;
  logic [D-1:0]  mf;
  logic [W-1:0]  md [D];
  logic [D-1:0]  mv;

  always @(posedge clk) frz <= (int'($urandom % 100) < frz_pct);

  always_comb begin
    snk_valid = mf[D-1] && !frz && !stall;
    snk_data  = md[D-1];
    mv[D-1]   = snk_valid && snk_ready;
    for (int i = D - 2; i >= 0; i--) mv[i] = mf[i] && !frz && (!mf[i+1] || mv[i+1]);
    src_ready = !frz && (!mf[0] || mv[0]);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mf <= '0;
      for (int i = 0; i < D; i++) md[i] <= '0;
    end else if (pre) begin
      mf <= '1;
      for (int i = 0; i < D; i++) md[i] <= pre_base + W'(i);
    end else begin
      if (src_valid && src_ready) begin
        mf[0] <= 1'b1;
        md[0] <= src_data;
      end else if (mv[0]) begin
        mf[0] <= 1'b0;
      end
      for (int i = 1; i < D; i++) begin
        if (mv[i-1]) begin
          mf[i] <= 1'b1;
          if (i == fwd_at && !mf[i]) md[i] <= '0;
          else if (i >= 2 && i == hold_at && mv[i-2]) md[i] <= md[i-2];
          else md[i] <= md[i-1];
        end else if (mv[i]) begin
          mf[i] <= 1'b0;
        end
      end
    end
  end

  // ---------------- bench reference ----------------
  function automatic logic [W-1:0] wordf(input int k);
    logic [W-1:0] m = '0;
    for (int b = 1; b < W; b += 2) m[b] = 1'b1;
    return W'(k) ^ m;
  endfunction

  // ---------------- monitor ----------------
  logic mon_clr = 1'b0;
  int cyc = 0, n_push = 0, push_bad = 0, first_empty = 0, fwd_ret = 0, fwd_order_bad = 0;
  int withhold_bad = 0, bub_seen = 0, bub_occ = 0, bub_cyc = 0, gap = 0, gap_set = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      n_push = 0; push_bad = 0; first_empty = 0; fwd_ret = 0; fwd_order_bad = 0;
      withhold_bad = 0; bub_seen = 0; bub_occ = 0; bub_cyc = 0; gap = 0; gap_set = 0;
    end else if (rst_n) begin
      if (src_valid && src_ready) begin
        if (src_data != wordf(n_push + 1)) push_bad = push_bad + 1;
        if (n_push == 0) first_empty = (mf == '0) ? 1 : 0;
        if (n_push == 1 && fwd_ret == 0) fwd_order_bad = fwd_order_bad + 1;
        n_push = n_push + 1;
      end
      if (snk_valid && snk_ready) begin
        if (n_push == 1) fwd_ret = 1;
        if (n_push >= 2 && bub_seen == 0) begin
          if (n_push < D + 1) withhold_bad = withhold_bad + 1;
          else begin
            bub_seen = 1;
            bub_occ = $countones(mf);
            bub_cyc = cyc;
          end
        end else if (bub_seen == 1 && gap_set == 0) begin
          gap = cyc - bub_cyc;
          gap_set = 1;
        end
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int f_at, input int h_at, input logic stl, input int fz,
                          input logic do_pre, input logic mid_start, input int exp_kind);
    int n;
    fwd_at = f_at; hold_at = h_at; stall = stl; frz_pct = fz;
    @(negedge clk);
    if (do_pre) begin
      pre_base = W'($urandom);
      pre = 1'b1;
      @(negedge clk);
      pre = 1'b0;
    end
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = (mid_start && n == 30);
    end
    start = 1'b0;
    frz_pct = 0;
    chk(done, "R9 run finished", int'(done), 1);
    chk(fault_kind == 2'(exp_kind), "R7/R8 fault kind", int'(fault_kind), exp_kind);
    if (exp_kind == 0) begin
      chk(pass, "R8 pass flag", int'(pass), 1);
      chk(n_push == D + 1 && push_bad == 0, "R3 R5 word stream", n_push, D + 1);
      chk(first_empty == 1, "R2 empty before injection", first_empty, 1);
      chk(fwd_order_bad == 0, "R3 lone word returned first", fwd_order_bad, 0);
      chk(withhold_bad == 0, "R5 no ack during fill", withhold_bad, 0);
      chk(bub_occ == D, "R6 full at release", bub_occ, D);
      chk(gap >= D, "R6 ack withheld after release", gap, D);
    end else if (exp_kind == 1) begin
      chk(!pass && fault_index == '0, "R4 forward index", int'(fault_index), 0);
      chk(n_push == 1, "R4 no fill after forward fault", n_push, 1);
    end else if (exp_kind == 2) begin
      chk(!pass && int'(fault_index) < D, "R7 reverse index range", int'(fault_index), D - 1);
      chk(n_push == D + 1, "R7 all fill words sent", n_push, D + 1);
    end else begin
      chk(fault_index == '0, "R9 timeout index", int'(fault_index), 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !pass && !src_valid && !snk_ready && fault_kind == 2'd0,
        "R1 reset state", int'({done, pass, src_valid, snk_ready}), 0);

    // directed: clean pipeline, stale preload
    run_case(0, 0, 1'b0, 0, 1'b0, 1'b0, 0);
    run_case(0, 0, 1'b0, 0, 1'b1, 1'b0, 0);

    // R10: results hold without start
    repeat (5) @(negedge clk);
    chk(done && pass && fault_kind == 2'd0, "R10 result held", int'(done), 1);

    // R10: start during a run is ignored
    run_case(0, 0, 1'b0, 0, 1'b1, 1'b1, 0);

    // directed corner boundaries
    run_case(1, 0, 1'b0, 0, 1'b0, 1'b0, 1);
    run_case(D - 1, 0, 1'b0, 0, 1'b1, 1'b0, 1);
    run_case(0, 2, 1'b0, 0, 1'b0, 1'b0, 2);
    run_case(0, D - 1, 1'b0, 0, 1'b1, 1'b0, 2);
    run_case(0, 0, 1'b1, 0, 1'b0, 1'b0, 3);

    // random: clean runs with random freezes and preloads
    for (int r = 0; r < 6; r++)
      run_case(0, 0, 1'b0, int'($urandom % 40), 1'($urandom), 1'b0, 0);
    // random fault locations
    for (int r = 0; r < 3; r++)
      run_case(1 + int'($urandom % (D - 1)), 0, 1'b0, 0, 1'($urandom), 1'b0, 1);
    for (int r = 0; r < 3; r++)
      run_case(0, 2 + int'($urandom % (D - 2)), 1'b0, 0, 1'($urandom), 1'b0, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule